// File: doc/BRIEF.md
# SPI Master Frame Engine with Per-Command Attribute Selection

This block is a single-lane SPI master. It takes one command at a time. Each command carries a data word, a one-bit selector and a counter-clear flag. The selector picks one of two 32-bit attribute words, and that word governs the frame: its length, SCK polarity, SCK phase, bit order and SCK rate. The engine asserts chip select, runs the frame on SCK/MOSI while it captures MISO, releases chip select, and presents the received bits right-justified together with a one-cycle done strobe.

A small register port writes both attribute words and a 16-bit transfer counter, and reads them back. The counter advances when a frame's final SCK edge is produced. A write presets it. A command whose clear flag is set zeroes it at frame start. Attribute words are frozen while a frame is in flight, so software can safely queue the next configuration between frames.

Attribute word layout (bit 31 is the most significant): [31] double-rate flag, [30:27] size code, [26] idle SCK level, [25] phase, [24] LSB-first, [23:4] timing fields that are stored but not used here, [3:0] rate code.

Top module: `spi_attr_master`

## Requirements
- R1: After reset, both attribute words read 0x7800_0000, the counter reads 0, cs_n is 1, sck is 0, mosi is 0, rx_valid is 0 and cmd_ready is 1. Register addresses: 0 = attribute word 0, 1 = attribute word 1, 2 = counter (bits 15:0), 3 reads 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. cmd_sel=0 runs the frame with attribute word 0, and cmd_sel=1 runs it with attribute word 1. The word is captured at acceptance.
- R3: The frame has size code + 1 bits (1 to 16). On rx_valid, rx_data holds the bits received from miso, right-justified, with all bits above the frame length at 0.
- R4: Let h = rate code + 1. If the double-rate flag is set, h is halved (rounding down), with a floor of 1. Each SCK half-period then lasts h clocks. With c counted in clocks after the acceptance edge, SCK edge k (k = 0 … 2N−1) occurs at c = (k+3)·h.
- R5: sck holds the idle level from acceptance onward. The first edge of each SCK period is the leading edge and the second is the trailing edge. SCK has exactly 2N edges and ends at the idle level. sck never changes while cs_n stays high.
- R6: Phase 0: the first data bit is on mosi from acceptance, mosi changes after each trailing edge, and miso is sampled on leading edges. Phase 1: mosi is 0 until the first leading edge, changes on leading edges, and miso is sampled on trailing edges. Bit order is MSB-first unless the LSB-first bit is set. mosi returns to 0 when the frame ends.
- R7: cs_n falls on the acceptance edge. It rises 2·h clocks after the last SCK edge, at c = (2N+4)·h. rx_valid is 1 for exactly that one cycle.
- R8: The counter increments by one on the edge that produces the frame's last SCK edge, and wraps from 0xFFFF to 0.
- R9: A register write to address 2 loads bits 15:0 into the counter, and takes priority over an increment in the same cycle.
- R10: If cmd_clr_cnt is 1 at acceptance, the counter becomes 0 on the acceptance edge, so that frame ends with the counter at 1.
- R11: Writes to address 0 or 1 while busy is 1 leave the attribute words unchanged.
- R12: cmd_ready is 1 only while no frame is in flight. A cmd_valid raised during a frame is not accepted and has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_sel | input | 1 | Attribute word selector |
| cmd_clr_cnt | input | 1 | Zero the counter at frame start |
| cmd_data | input | DATA_W | Data to shift out |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xfer_count | output | CNT_W | Transfer counter |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in flight |
| rx_valid | output | 1 | One-cycle done strobe |
| rx_data | output | DATA_W | Received frame, right-justified |

## Verification
The bench goes after the frames where the edge arithmetic is easiest to get wrong. These are a single-bit frame at the fastest rate, where a design that mishandles the last shift would emit an extra SCK period, and double-rate with rate codes 0 and 4, where a missing floor gives a zero-length half-period that stalls the timer. It runs both phases in both bit orders against a waveform rebuilt every clock, so a sample taken on the wrong edge or a reversed bit order shows up as a MOSI or rx_data mismatch at a known cycle. It presets the counter to 0xFFFF so that a missing wrap reads 0x10000-truncated garbage, and uses the clear flag on a non-zero count to catch a clear applied after the increment. It also writes an attribute word and raises cmd_valid mid-frame, which a design lacking the lock would show as a changed readback or a restarted frame.

// File: rtl/spi_attr_pkg.sv
package spi_attr_pkg;

  localparam int IDX_W = 5;  // holds 0..16 frame-bit indices

  typedef struct packed {
    logic        dbl;        // halve the SCK half-period
    logic [3:0]  fsz;        // frame bits minus one
    logic        cpol;       // SCK idle level
    logic        cpha;       // 0: sample leading, 1: sample trailing
    logic        lsb_first;  // bit order
    logic [7:0]  pre;        // stored timing prescalers, unused here
    logic [11:0] dly;        // stored timing scalers, unused here
    logic [3:0]  br;         // rate code
  } attr_t;

  localparam logic [31:0] ATTR_RST = 32'h7800_0000;

  localparam logic [1:0] ADDR_ATTR0 = 2'd0;
  localparam logic [1:0] ADDR_ATTR1 = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} eng_state_t;

  // Clocks per SCK half-period.
  function automatic logic [IDX_W-1:0] half_clocks(attr_t a);
    logic [IDX_W-1:0] base;
    base = {1'b0, a.br} + 5'd1;
    if (a.dbl) begin
      base = base >> 1;
      if (base == 5'd0) base = 5'd1;
    end
    return base;
  endfunction

  // Frame length in bits.
  function automatic logic [IDX_W-1:0] frame_len(attr_t a);
    return {1'b0, a.fsz} + 5'd1;
  endfunction

  // Data-word position of the j-th bit on the wire.
  function automatic logic [IDX_W-1:0] bit_slot(logic [IDX_W-1:0] j,
                                                logic [IDX_W-1:0] n,
                                                logic lsb);
    return lsb ? j : (n - 5'd1 - j);
  endfunction

endpackage

// File: rtl/spi_attr_timer.sv
module spi_attr_timer #(
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt_q;

  assign tick = (cnt_q == half - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/spi_attr_shifter.sv
module spi_attr_shifter
  import spi_attr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              done,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic [IDX_W-1:0]  nbits_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              lead_edge,
  input  logic              trail_edge,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  localparam int SW = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [IDX_W-1:0]  n_q, oidx_q, sidx_q;
  logic              lsb_q, cpha_q, mosi_q;

  logic [IDX_W-1:0] o_pos, o_pos_nx, s_pos, first_pos;
  assign o_pos     = bit_slot(oidx_q, n_q, lsb_q);
  assign o_pos_nx  = bit_slot(oidx_q + IDX_W'(1), n_q, lsb_q);
  assign s_pos     = bit_slot(sidx_q, n_q, lsb_q);
  assign first_pos = bit_slot('0, nbits_i, lsb_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      n_q    <= IDX_W'(1);
      oidx_q <= '0;
      sidx_q <= '0;
      lsb_q  <= 1'b0;
      cpha_q <= 1'b0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_q   <= tx_i;
      rx_q   <= '0;
      n_q    <= nbits_i;
      oidx_q <= '0;
      sidx_q <= '0;
      lsb_q  <= lsb_i;
      cpha_q <= cpha_i;
      mosi_q <= cpha_i ? 1'b0 : tx_i[first_pos[SW-1:0]];
    end else begin
      if (lead_edge) begin
        if (cpha_q) begin
          mosi_q <= tx_q[o_pos[SW-1:0]];
          oidx_q <= oidx_q + IDX_W'(1);
        end else begin
          rx_q[s_pos[SW-1:0]] <= miso;
          sidx_q <= sidx_q + IDX_W'(1);
        end
      end
      if (trail_edge) begin
        if (cpha_q) begin
          rx_q[s_pos[SW-1:0]] <= miso;
          sidx_q <= sidx_q + IDX_W'(1);
        end else if (oidx_q + IDX_W'(1) < n_q) begin
          mosi_q <= tx_q[o_pos_nx[SW-1:0]];
          oidx_q <= oidx_q + IDX_W'(1);
        end
      end
      if (done) mosi_q <= 1'b0;
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/spi_attr_regs.sv
module spi_attr_regs
  import spi_attr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_ATTR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wr_data,
  input  logic             busy,
  input  logic             cnt_clr,
  input  logic             cnt_inc,
  input  logic             sel,
  output attr_t            attr_sel,
  output logic [31:0]      attr0,
  output logic [31:0]      attr1,
  output logic [31:0]      rd_data,
  output logic [CNT_W-1:0] count
);
  logic [31:0]      bank_q [N_ATTR];
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_wr;

  assign cnt_wr = wr_en && (addr == ADDR_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ATTR; i++) bank_q[i] <= ATTR_RST;
    end else if (wr_en && !busy) begin
      for (int i = 0; i < N_ATTR; i++)
        if (addr == 2'(i)) bank_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= wr_data[CNT_W-1:0];
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_inc) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign attr0    = bank_q[0];
  assign attr1    = bank_q[1];
  assign attr_sel = sel ? attr_t'(bank_q[1]) : attr_t'(bank_q[0]);
  assign count    = cnt_q;

  always_comb begin
    case (addr)
      ADDR_ATTR0: rd_data = bank_q[0];
      ADDR_ATTR1: rd_data = bank_q[1];
      ADDR_COUNT: rd_data = 32'(cnt_q);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spi_attr_master.sv
module spi_attr_master
  import spi_attr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_sel,
  input  logic              cmd_clr_cnt,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int EDGE_W = IDX_W + 1;

  eng_state_t        state_q;
  logic              ph_q;
  logic [EDGE_W-1:0] edge_q;
  logic [IDX_W-1:0]  half_q, nbits_q;
  logic              sck_q, cs_n_q, rxv_q;
  logic [DATA_W-1:0] rxd_q, rx_word;

  // Named internal events
  attr_t             attr_sel;
  logic [31:0]       attr0_w, attr1_w;
  logic              tick, accept, done;
  logic              lead_edge, trail_edge, last_edge;
  logic              cnt_inc, cnt_clr;
  logic [EDGE_W-1:0] last_idx;

  assign accept     = cmd_valid && (state_q == ST_IDLE);
  assign last_idx   = {nbits_q, 1'b0} - EDGE_W'(1);
  assign lead_edge  = (state_q == ST_XFER) && tick && !edge_q[0];
  assign trail_edge = (state_q == ST_XFER) && tick &&  edge_q[0];
  assign last_edge  = (state_q == ST_XFER) && tick && (edge_q == last_idx);
  assign done       = (state_q == ST_TRAIL) && tick && ph_q;
  assign cnt_inc    = last_edge;
  assign cnt_clr    = accept && cmd_clr_cnt;

  spi_attr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_we),
    .addr     (reg_addr),
    .wr_data  (reg_wdata),
    .busy     (busy),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .sel      (cmd_sel),
    .attr_sel (attr_sel),
    .attr0    (attr0_w),
    .attr1    (attr1_w),
    .rd_data  (reg_rdata),
    .count    (xfer_count)
  );

  spi_attr_timer #(.HW(IDX_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .half    (half_q),
    .tick    (tick)
  );

  spi_attr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .done       (done),
    .cpha_i     (attr_sel.cpha),
    .lsb_i      (attr_sel.lsb_first),
    .nbits_i    (frame_len(attr_sel)),
    .tx_i       (cmd_data),
    .lead_edge  (lead_edge),
    .trail_edge (trail_edge),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      edge_q  <= '0;
      half_q  <= IDX_W'(1);
      nbits_q <= IDX_W'(1);
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_LEAD;
          ph_q    <= 1'b0;
          edge_q  <= '0;
          half_q  <= half_clocks(attr_sel);
          nbits_q <= frame_len(attr_sel);
          sck_q   <= attr_sel.cpol;
          cs_n_q  <= 1'b0;
        end
        ST_LEAD: if (tick) begin
          ph_q <= ~ph_q;
          if (ph_q) state_q <= ST_XFER;
        end
        ST_XFER: if (tick) begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + EDGE_W'(1);
          if (last_edge) begin
            state_q <= ST_TRAIL;
            ph_q    <= 1'b0;
          end
        end
        ST_TRAIL: if (tick) begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxv_q <= 1'b0;
      rxd_q <= '0;
    end else begin
      rxv_q <= done;
      if (done) rxd_q <= rx_word;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign rx_valid  = rxv_q;
  assign rx_data   = rxd_q;
endmodule

// File: rtl/spi_attr_checker.sv
module spi_attr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             cs_n,
  input logic             sck,
  input logic             rx_valid,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [CNT_W-1:0] wdata_lo,
  input logic [CNT_W-1:0] xfer_count,
  input logic             cnt_inc,
  input logic             cnt_clr,
  input logic [31:0]      attr0,
  input logic [31:0]      attr1
);
  logic cnt_wr;
  assign cnt_wr = reg_we && (reg_addr == 2'd2);

  p_cs_high_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_done_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(cs_n));

  p_sck_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> $stable(sck));

  p_accept_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_ready) |-> (busy && !cs_n));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_inc) && !$past(cnt_wr)) |-> (xfer_count == $past(xfer_count) + CNT_W'(1)));

  p_cnt_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_wr) |-> (xfer_count == $past(wdata_lo)));

  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_clr) && !$past(cnt_wr)) |-> (xfer_count == '0));

  p_attr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(attr0) && $stable(attr1)));
endmodule

bind spi_attr_master spi_attr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .cs_n       (cs_n),
  .sck        (sck),
  .rx_valid   (rx_valid),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .wdata_lo   (reg_wdata[CNT_W-1:0]),
  .xfer_count (xfer_count),
  .cnt_inc    (cnt_inc),
  .cnt_clr    (cnt_clr),
  .attr0      (attr0_w),
  .attr1      (attr1_w)
);

// File: tb/spi_attr_master_test.sv
module spi_attr_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_sel = 1'b0, cmd_clr_cnt = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] xfer_count, rx_data;
  logic        cmd_ready, sck, cs_n, mosi, miso, busy, rx_valid;
  logic        flip = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_attr [2];
  int m_cnt = 0;

  always #2 clk = ~clk;
  assign miso = mosi ^ flip;

  spi_attr_master uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_clr_cnt(cmd_clr_cnt), .cmd_data(cmd_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .xfer_count(xfer_count), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit dbl, int fsz, bit cpol, bit cpha, bit lsb, int br);
    return {dbl, 4'(fsz), cpol, cpha, lsb, 8'h96, 12'hA5A, 4'(br)};
  endfunction

  task automatic read_chk(input int addr, input int exp, input string req);
    @(negedge clk);
    reg_addr = 2'(addr);
    #1;
    chk(req, "register readback", int'(reg_rdata), exp);
  endtask

  task automatic write_reg(input int addr, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(addr); reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
    if (addr < 2) m_attr[addr] = val;
    else if (addr == 2) m_cnt = int'(val[15:0]);
  endtask

  // One frame against a waveform rebuilt from the requirements each clock.
  task automatic run_frame(input int sel, input bit clr, input logic [15:0] data,
                           input bit fl, input bit poke);
    logic [31:0] a;
    int n, h, cpol, cpha, lsb, last, base, exp_rx;
    a    = m_attr[sel];
    n    = int'(a[30:27]) + 1;
    cpol = int'(a[26]);
    cpha = int'(a[25]);
    lsb  = int'(a[24]);
    h    = int'(a[3:0]) + 1;
    if (a[31]) h = h / 2;
    if (h < 1) h = 1;
    last = (2 * n + 4) * h;
    base = clr ? 0 : m_cnt;
    exp_rx = int'(data ^ (fl ? 16'hFFFF : 16'h0000)) & ((1 << n) - 1);

    @(negedge clk);
    chk("R12", "ready before command", int'(cmd_ready), 1);
    flip = fl; cmd_valid = 1'b1; cmd_sel = 1'(sel); cmd_clr_cnt = clr;
    cmd_data = data; reg_addr = 2'(sel);
    for (int c = 0; c <= last; c++) begin
      int e, es, em, ec, j, lead;
      @(negedge clk);
      cmd_valid = 1'b0;
      e  = (c < 3 * h) ? 0 : ((c / h - 2) > 2 * n ? 2 * n : c / h - 2);
      es = cpol ^ (e % 2);
      if (c == last) em = 0;
      else if (cpha == 0) begin
        j  = (e / 2 > n - 1) ? n - 1 : e / 2;
        em = int'(data[lsb ? j : n - 1 - j]);
      end else begin
        lead = (e + 1) / 2;
        em = (lead == 0) ? 0 : int'(data[lsb ? lead - 1 : n - lead]);
      end
      ec = (c >= (2 * n + 2) * h) ? ((base + 1) & 16'hFFFF) : base;
      chk("R4/R5", "sck", int'(sck), es);
      chk("R6", "mosi", int'(mosi), em);
      chk("R7", "cs_n", int'(cs_n), (c == last) ? 1 : 0);
      chk("R7", "rx_valid", int'(rx_valid), (c == last) ? 1 : 0);
      chk("R12", "cmd_ready", int'(cmd_ready), (c == last) ? 1 : 0);
      chk("R8/R10", "counter", int'(xfer_count), ec);
      if (c == last) chk("R3", "rx_data", int'(rx_data), exp_rx);
      if (poke && c == 0) begin
        reg_we = 1'b1; reg_addr = 2'(sel); reg_wdata = 32'hFFFF_FFFF;
        cmd_valid = 1'b1; cmd_data = ~data;
      end
      if (poke && c == 1) reg_we = 1'b0;
    end
    m_cnt = (base + 1) & 16'hFFFF;
    @(negedge clk);
    chk("R7", "rx_valid drops", int'(rx_valid), 0);
    chk("R7", "cs_n stays high", int'(cs_n), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_attr[0] = 32'h7800_0000;
    m_attr[1] = 32'h7800_0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1", "cs_n", int'(cs_n), 1);
    chk("R1", "sck", int'(sck), 0);
    chk("R1", "mosi", int'(mosi), 0);
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "cmd_ready", int'(cmd_ready), 1);
    read_chk(0, 32'h7800_0000, "R1");
    read_chk(1, 32'h7800_0000, "R1");
    read_chk(2, 0, "R1");
    read_chk(3, 0, "R1");

    // R2/R3: reset attributes, 16-bit MSB-first frame
    run_frame(0, 1'b0, 16'hA5C3, 1'b0, 1'b0);
    // R5/R6/R10: idle-high, phase 1, LSB-first, 8 bits, h=3, clear on non-zero count
    write_reg(1, mk(1'b0, 7, 1'b1, 1'b1, 1'b1, 2));
    read_chk(1, mk(1'b0, 7, 1'b1, 1'b1, 1'b1, 2), "R11");
    run_frame(1, 1'b1, 16'h1234, 1'b1, 1'b0);
    read_chk(2, 1, "R10");
    // R4: double rate, rate code 4 -> h=2; 5 bits, phase 1 MSB-first
    write_reg(0, mk(1'b1, 4, 1'b0, 1'b1, 1'b0, 4));
    run_frame(0, 1'b0, 16'h0016, 1'b0, 1'b0);
    // R4/R3: double rate floor, single-bit frame, phase 0 LSB-first
    write_reg(0, mk(1'b1, 0, 1'b0, 1'b0, 1'b1, 0));
    run_frame(0, 1'b0, 16'h0001, 1'b1, 1'b0);
    // R2: word 1 re-selected with new shape, 12 bits, h=2
    write_reg(1, mk(1'b0, 11, 1'b0, 1'b0, 1'b0, 1));
    run_frame(1, 1'b0, 16'hBEEF, 1'b0, 1'b0);
    // R8 wrap after R9 preset
    write_reg(2, 32'h0000_FFFF);
    read_chk(2, 16'hFFFF, "R9");
    run_frame(0, 1'b0, 16'h0000, 1'b0, 1'b0);
    read_chk(2, 0, "R8");
    // R9 preset then R10 clear
    write_reg(2, 32'hABCD_0010);
    read_chk(2, 16'h0010, "R9");
    run_frame(1, 1'b1, 16'h0F0F, 1'b1, 1'b0);
    read_chk(2, 1, "R10");
    // R11/R12: attribute write and second command during a frame
    run_frame(1, 1'b0, 16'h5A3C, 1'b0, 1'b1);
    read_chk(1, mk(1'b0, 11, 1'b0, 1'b0, 1'b0, 1), "R11");
    read_chk(2, 2, "R12");
    // R2: word 0 still governs sel=0 after word 1 traffic
    run_frame(0, 1'b0, 16'h0000, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule